// File: doc/BRIEF.md
# Serial Program Memory Loader

This block fills a 16-bit-wide program memory from a serial bit stream while the processor core is held in reset. An external device supplies a data line and a load clock. The block samples the data line once for each rising edge of the load clock, gathers the bits most-significant first into words, and writes each finished word to the next memory address, starting from address zero.

The load clock, the address-restart strobe, the load-complete line and the chip hold line are all asynchronous to the system clock. Each one passes through a synchroniser, and its edges are detected in the system clock domain. The address-restart strobe is qualified: it must be high at two or more successive load-clock rising edges before the address returns to zero. A rising edge on load-complete closes the loading session. Any bits still pending at that point are dropped and flagged. The run-enable to the core rises only once the hold line is released after such an edge. If the hold is released without a load-complete edge, run-enable stays low.

When more words arrive than the memory can hold, a sticky overflow flag is raised. A build-time policy then selects between two behaviours: the extra words can be dropped with the address held at the top, or the address can wrap to zero.

Top module: `prog_sload`

## Requirements
- R1: Within each word, the first sampled bit lands in bit 15 and the sixteenth sampled bit lands in bit 0.
- R2: Every sixteen sampled bits produce exactly one write, lasting one clock, with mem_we high. Writes go to consecutive addresses starting at 0 after a session opens.
- R3: Bits are taken only on rising edges of lclk. Changes of sdata without a load-clock rising edge cause no write.
- R4: While hold_n is high, load-clock edges are ignored and no write occurs.
- R5: If addr_clr is high at two consecutive load-clock rising edges, the second of those edges sets the next write address to 0 and discards pending bits; the bit sampled at that edge is not used. An edge where addr_clr is high but the count is not reached still shifts in its bit.
- R6: If addr_clr is high at only one load-clock rising edge, the address is not reset and that edge's bit is kept as data.
- R7: After a rising edge of ld_done, load-clock edges produce no writes until the next session.
- R8: If bits of an unfinished word are pending when ld_done rises, they are discarded and part_flag goes high and stays high for the rest of the session.
- R9: core_run is high only while hold_n is high and an ld_done rising edge has been seen in the current session. Releasing hold_n without that edge leaves core_run low.
- R10: A word that completes after the last address has been written sets ovf_flag, which stays high for the rest of the session. Under the saturate policy (default) that word is not written. Under the wrap policy it is written at address 0.
- R11: After rst_n the block is in a loading session with mem_we, core_run, ovf_flag and part_flag low and the next write address 0.
- R12: A falling edge of hold_n opens a new session: core_run goes low, ovf_flag and part_flag clear, and the next word is written at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's own state |
| hold_n | input | 1 | Active-low chip hold; loading is allowed while it is low |
| lclk | input | 1 | Load clock; data is sampled on its rising edge |
| sdata | input | 1 | Serial program data, most-significant bit first |
| addr_clr | input | 1 | Address-restart strobe, qualified by load-clock edges |
| ld_done | input | 1 | Load-complete; its rising edge ends the session |
| mem_we | output | 1 | Program memory write strobe |
| mem_addr | output | ADDR_W | Program memory write address |
| mem_wdata | output | DATA_W | Program memory write word |
| core_run | output | 1 | Core may fetch from program memory |
| ovf_flag | output | 1 | Sticky: a word arrived after the memory was full |
| part_flag | output | 1 | Sticky: an unfinished word was discarded at load-complete |

## Verification
The bench builds two copies of the block with the memory depth cut to six words: one with the saturate policy and one with the wrap policy, both driven by the same stimulus. The small depth lets a short run fill the whole address range and push past it. This covers the top-address boundary, the saturate hold, the wrap to zero and the overflow flag, which the full 8K-word depth would never reach within the run. The 16-bit word width and the two-edge strobe qualification are kept at their defaults, so bit packing and strobe handling are checked as built.

// File: rtl/prog_sload_pkg.sv
package prog_sload_pkg;

   typedef enum logic {
      OVF_SATURATE = 1'b0,
      OVF_WRAP     = 1'b1
   } ovf_policy_e;

   function automatic int unsigned addr_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/psl_sync.sv
module psl_sync #(
   parameter int unsigned      WIDTH   = 1,
   parameter int unsigned      STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] rise,
   output logic [WIDTH-1:0] fall
);

   logic [WIDTH-1:0] chain_q [STAGES];
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
         prev_q <= RST_VAL;
      end else begin
         chain_q[0] <= d_in;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
         prev_q <= chain_q[STAGES-1];
      end
   end

   assign lvl  = chain_q[STAGES-1];
   assign rise = chain_q[STAGES-1] & ~prev_q;
   assign fall = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/psl_packer.sv
module psl_packer #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic              word_done,
   output logic [DATA_W-1:0] word,
   output logic              pending
);

   localparam int unsigned       CNT_W    = $clog2(DATA_W);
   localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;

   always_comb begin
      word      = {sh_q[DATA_W-2:0], bit_in};
      word_done = shift_en && (cnt_q == LAST_BIT);
      pending   = (cnt_q != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         cnt_q <= '0;
      end else if (shift_en) begin
         sh_q  <= word;
         cnt_q <= word_done ? '0 : cnt_q + 1'b1;
      end
   end

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !pending) else $error("flush left bits pending"); // R5

endmodule

// File: rtl/psl_addr_gen.sv
module psl_addr_gen
   import prog_sload_pkg::*;
#(
   parameter int unsigned ADDR_W     = 13,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned MEM_WORDS  = 8192,
   parameter int unsigned STROBE_MIN = 2,
   parameter ovf_policy_e POLICY     = OVF_SATURATE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              edge_en,
   input  logic              clr_lvl,
   input  logic              word_done,
   input  logic [DATA_W-1:0] word,
   output logic              clr_fire,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              ovf_flag
);

   localparam int unsigned       SC_W      = $clog2(STROBE_MIN + 1);
   localparam logic [SC_W-1:0]   SC_FIRE   = SC_W'(STROBE_MIN - 1);
   localparam logic [SC_W-1:0]   SC_TOP    = SC_W'(STROBE_MIN);
   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(MEM_WORDS - 1);

   logic [SC_W-1:0]   sc_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_nxt;
   logic              full_q;
   logic              ovf_q;
   logic              wr_ok;

   // strobe qualification: consecutive load-clock edges with the strobe high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sc_q <= '0;
      else if (restart)  sc_q <= '0;
      else if (edge_en)  sc_q <= !clr_lvl ? '0 : ((sc_q == SC_TOP) ? sc_q : sc_q + 1'b1);
   end

   assign clr_fire = edge_en && clr_lvl && (sc_q == SC_FIRE);

   generate
      if (POLICY == OVF_WRAP) begin : g_wrap
         assign wr_ok    = word_done;
         assign addr_nxt = (addr_q == LAST_ADDR) ? '0 : addr_q + 1'b1;
      end else begin : g_sat
         assign wr_ok    = word_done && !full_q;
         assign addr_nxt = (addr_q == LAST_ADDR) ? addr_q : addr_q + 1'b1;

         AST_SAT_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (full_q && !restart && !clr_fire) |=> $stable(addr_q))
            else $error("address moved while saturated"); // R10
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q    <= '0;
         full_q    <= 1'b0;
         ovf_q     <= 1'b0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         mem_we <= wr_ok;
         if (wr_ok) begin
            mem_addr  <= addr_q;
            mem_wdata <= word;
         end
         if (restart) begin
            addr_q <= '0;
            full_q <= 1'b0;
            ovf_q  <= 1'b0;
         end else if (clr_fire) begin
            addr_q <= '0;
            full_q <= 1'b0;
         end else if (word_done) begin
            if (full_q) ovf_q <= 1'b1;
            if (wr_ok) begin
               addr_q <= addr_nxt;
               if (addr_q == LAST_ADDR) full_q <= 1'b1;
            end
         end
      end
   end

   assign ovf_flag = ovf_q;

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(addr_q) |-> ((addr_q == $past(addr_q) + 1'b1) || (addr_q == '0)))
      else $error("address jumped"); // R2

   AST_CLR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr_fire |=> (addr_q == '0)) else $error("strobe did not clear address"); // R5

endmodule

// File: rtl/psl_run_gate.sv
module psl_run_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_lvl,
   input  logic hold_fall,
   input  logic done_rise,
   input  logic pending,
   output logic closed,
   output logic core_run,
   output logic part_flag
);

   logic done_q;
   logic part_q;
   logic run_q;
   logic take_done;

   assign take_done = done_rise && !hold_lvl && !done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         part_q <= 1'b0;
         run_q  <= 1'b0;
      end else begin
         run_q <= hold_lvl && done_q;
         if (hold_fall) begin
            done_q <= 1'b0;
            part_q <= 1'b0;
         end else if (take_done) begin
            done_q <= 1'b1;
            if (pending) part_q <= 1'b1;
         end
      end
   end

   assign closed    = done_q;
   assign core_run  = run_q;
   assign part_flag = part_q;

   AST_RUN_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      core_run |-> done_q) else $error("run without load-complete"); // R9

   AST_PART_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(part_q) |-> $past(done_rise)) else $error("partial flag without load-complete"); // R8

endmodule

// File: rtl/prog_sload.sv
module prog_sload
   import prog_sload_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned MEM_WORDS   = 8192,
   parameter int unsigned ADDR_W      = addr_bits(MEM_WORDS),
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned STROBE_MIN  = 2,
   parameter ovf_policy_e OVF_POLICY  = OVF_SATURATE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_n,
   input  logic              lclk,
   input  logic              sdata,
   input  logic              addr_clr,
   input  logic              ld_done,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              core_run,
   output logic              ovf_flag,
   output logic              part_flag
);

   localparam int unsigned NSYNC  = 5;
   localparam int unsigned IX_HLD = 0;
   localparam int unsigned IX_LCK = 1;
   localparam int unsigned IX_DAT = 2;
   localparam int unsigned IX_CLR = 3;
   localparam int unsigned IX_DON = 4;

   generate
      if (DATA_W < 2)               begin : g_chk_w  $error("DATA_W must be at least 2"); end
      if (MEM_WORDS < 2)            begin : g_chk_d  $error("MEM_WORDS must be at least 2"); end
      if (ADDR_W < addr_bits(MEM_WORDS)) begin : g_chk_a $error("ADDR_W too narrow for MEM_WORDS"); end
      if (SYNC_STAGES < 2)          begin : g_chk_s  $error("SYNC_STAGES must be at least 2"); end
      if (STROBE_MIN < 1)           begin : g_chk_t  $error("STROBE_MIN must be at least 1"); end
   endgenerate

   logic [NSYNC-1:0] s_lvl, s_rise, s_fall;
   logic [NSYNC-1:0] raw_in;

   assign raw_in[IX_HLD] = hold_n;
   assign raw_in[IX_LCK] = lclk;
   assign raw_in[IX_DAT] = sdata;
   assign raw_in[IX_CLR] = addr_clr;
   assign raw_in[IX_DON] = ld_done;

   psl_sync #(
      .WIDTH   (NSYNC),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ('0)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (raw_in),
      .lvl   (s_lvl),
      .rise  (s_rise),
      .fall  (s_fall)
   );

   logic hold_lvl, hold_fall, lclk_rise, done_rise;
   logic closed, load_act, edge_en, shift_en, flush;
   logic clr_fire, word_done, pending;
   logic [DATA_W-1:0] word;

   assign hold_lvl  = s_lvl[IX_HLD];
   assign hold_fall = s_fall[IX_HLD];
   assign lclk_rise = s_rise[IX_LCK];
   assign done_rise = s_rise[IX_DON];

   assign load_act = !hold_lvl && !closed;
   assign edge_en  = lclk_rise && load_act && !done_rise && !hold_fall;
   assign shift_en = edge_en && !clr_fire;
   assign flush    = hold_fall || clr_fire || (done_rise && load_act);

   psl_packer #(
      .DATA_W (DATA_W)
   ) pack_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .shift_en  (shift_en),
      .bit_in    (s_lvl[IX_DAT]),
      .word_done (word_done),
      .word      (word),
      .pending   (pending)
   );

   psl_addr_gen #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .MEM_WORDS  (MEM_WORDS),
      .STROBE_MIN (STROBE_MIN),
      .POLICY     (OVF_POLICY)
   ) agen_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (hold_fall),
      .edge_en   (edge_en),
      .clr_lvl   (s_lvl[IX_CLR]),
      .word_done (word_done),
      .word      (word),
      .clr_fire  (clr_fire),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .ovf_flag  (ovf_flag)
   );

   psl_run_gate gate_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold_lvl  (hold_lvl),
      .hold_fall (hold_fall),
      .done_rise (done_rise),
      .pending   (pending),
      .closed    (closed),
      .core_run  (core_run),
      .part_flag (part_flag)
   );

   AST_NO_WRITE_WHEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      core_run |-> !mem_we) else $error("write while core running"); // R4

   AST_CLOSED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (closed && $past(closed)) |-> !mem_we) else $error("write after load-complete"); // R7

endmodule

// File: tb/prog_sload_tb_top.sv
module prog_sload_tb_top;
   import prog_sload_pkg::*;

   localparam int unsigned MW  = 6;
   localparam int unsigned AW  = addr_bits(MW);
   localparam int unsigned DW  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hold_n = 1'b0;
   logic lclk = 1'b0;
   logic sdata = 1'b0;
   logic addr_clr = 1'b0;
   logic ld_done = 1'b0;

   logic          we   [2];
   logic [AW-1:0] wa   [2];
   logic [DW-1:0] wd   [2];
   logic          run  [2];
   logic          ovf  [2];
   logic          part [2];

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   prog_sload #(.DATA_W(DW), .MEM_WORDS(MW), .OVF_POLICY(OVF_SATURATE)) dut_i (
      .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .lclk(lclk), .sdata(sdata),
      .addr_clr(addr_clr), .ld_done(ld_done), .mem_we(we[0]), .mem_addr(wa[0]),
      .mem_wdata(wd[0]), .core_run(run[0]), .ovf_flag(ovf[0]), .part_flag(part[0]));

   prog_sload #(.DATA_W(DW), .MEM_WORDS(MW), .OVF_POLICY(OVF_WRAP)) dut_w (
      .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .lclk(lclk), .sdata(sdata),
      .addr_clr(addr_clr), .ld_done(ld_done), .mem_we(we[1]), .mem_addr(wa[1]),
      .mem_wdata(wd[1]), .core_run(run[1]), .ovf_flag(ovf[1]), .part_flag(part[1]));

   // ---------------- reference model ----------------
   int          m_addr [2];
   int          m_nb   [2];
   logic [15:0] m_bits [2];
   bit          m_full [2];
   bit          m_ovf  [2];
   bit          m_part [2];
   bit          m_done [2];
   int          m_sc   [2];
   bit          m_hold = 1'b0;
   logic [15:0] emem [2][MW];
   logic [15:0] dmem [2][MW];
   int          exp_cnt [2];
   int          got_cnt [2];
   logic [31:0] q0 [$];
   logic [31:0] q1 [$];

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic void push_exp(input int p, input int a, input logic [15:0] d);
      if (p == 0) q0.push_back({16'(a), d}); else q1.push_back({16'(a), d});
      emem[p][a] = d;
      exp_cnt[p]++;
   endfunction

   function automatic void model_reset();
      for (int p = 0; p < 2; p++) begin
         m_addr[p] = 0; m_nb[p] = 0; m_bits[p] = '0; m_full[p] = 0;
         m_ovf[p] = 0; m_part[p] = 0; m_done[p] = 0; m_sc[p] = 0;
      end
   endfunction

   function automatic void model_edge(input bit b);
      for (int p = 0; p < 2; p++) begin
         if (m_hold || m_done[p]) continue;
         if (addr_clr) begin
            if (m_sc[p] < 2) begin
               m_sc[p]++;
               if (m_sc[p] == 2) begin
                  m_addr[p] = 0; m_nb[p] = 0; m_full[p] = 0;
                  continue;
               end
            end
         end else begin
            m_sc[p] = 0;
         end
         m_bits[p] = {m_bits[p][14:0], b};
         m_nb[p]++;
         if (m_nb[p] == 16) begin
            m_nb[p] = 0;
            if (m_full[p]) begin
               m_ovf[p] = 1;
               if (p == 0) continue;
            end
            push_exp(p, m_addr[p], m_bits[p]);
            if (m_addr[p] == MW - 1) begin
               m_full[p] = 1;
               m_addr[p] = (p == 0) ? MW - 1 : 0;
            end else begin
               m_addr[p]++;
            end
         end
      end
   endfunction

   // ---------------- write monitor ----------------
   always @(negedge clk) begin
      for (int p = 0; p < 2; p++) begin
         if (rst_n && we[p]) begin
            logic [31:0] e;
            got_cnt[p]++;
            dmem[p][wa[p]] = wd[p];
            if ((p == 0 && q0.size() == 0) || (p == 1 && q1.size() == 0)) begin
               check(1'b0, "R2", "unexpected write addr/data", {16'(wa[p]), wd[p]}, 0);
            end else begin
               e = (p == 0) ? q0.pop_front() : q1.pop_front();
               check({16'(wa[p]), wd[p]} == e, "R2", "write addr/data",
                     {16'(wa[p]), wd[p]}, e);
            end
         end
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input bit b);
      @(negedge clk);
      sdata = b;
      waitc(4);
      lclk = 1'b1;
      model_edge(b);
      waitc(4);
      lclk = 1'b0;
   endtask

   task automatic send_word(input logic [15:0] w);
      for (int i = 15; i >= 0; i--) send_bit(w[i]);
   endtask

   task automatic pulse_done();
      @(negedge clk);
      ld_done = 1'b1;
      for (int p = 0; p < 2; p++) begin
         if (!m_hold && !m_done[p]) begin
            m_done[p] = 1;
            if (m_nb[p] != 0) m_part[p] = 1;
            m_nb[p] = 0;
         end
      end
      waitc(6);
      ld_done = 1'b0;
      waitc(6);
   endtask

   task automatic set_hold(input bit v);
      @(negedge clk);
      if (m_hold && !v) model_reset();
      m_hold = v;
      hold_n = v;
      waitc(8);
   endtask

   task automatic check_flags(input string req);
      waitc(6);
      for (int p = 0; p < 2; p++) begin
         check(ovf[p] == m_ovf[p], req, $sformatf("ovf_flag dut%0d", p), ovf[p], m_ovf[p]);
         check(part[p] == m_part[p], req, $sformatf("part_flag dut%0d", p), part[p], m_part[p]);
         check(run[p] == (m_hold && m_done[p]), req, $sformatf("core_run dut%0d", p),
               run[p], m_hold && m_done[p]);
      end
   endtask

   task automatic check_count(input string req);
      waitc(6);
      for (int p = 0; p < 2; p++)
         check(got_cnt[p] == exp_cnt[p], req, $sformatf("write count dut%0d", p),
               got_cnt[p], exp_cnt[p]);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #1_900_000;
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      model_reset();
      for (int p = 0; p < 2; p++) begin
         exp_cnt[p] = 0; got_cnt[p] = 0;
         for (int a = 0; a < MW; a++) begin emem[p][a] = '0; dmem[p][a] = '0; end
      end
      waitc(5);
      rst_n = 1'b1;
      waitc(4);

      // R11: reset state
      for (int p = 0; p < 2; p++) begin
         check(we[p] == 1'b0, "R11", "mem_we after reset", we[p], 0);
         check(run[p] == 1'b0, "R11", "core_run after reset", run[p], 0);
         check(ovf[p] == 1'b0, "R11", "ovf_flag after reset", ovf[p], 0);
         check(part[p] == 1'b0, "R11", "part_flag after reset", part[p], 0);
      end

      // R1, R2: MSB-first packing, sequential addresses from 0
      send_word(16'hA5C3);
      send_word(16'h1234);
      check_count("R1");

      // R3: sdata toggling without load-clock edges
      for (int i = 0; i < 20; i++) begin @(negedge clk); sdata = ~sdata; end
      check_count("R3");

      // R6: single-edge strobe is data, address kept (word lands at 2)
      addr_clr = 1'b1;
      send_bit(1'b1);
      addr_clr = 1'b0;
      for (int i = 14; i >= 0; i--) send_bit(i[0]);
      check_count("R6");

      // R5: partial bits then a two-edge strobe, next word at address 0
      for (int i = 0; i < 5; i++) send_bit(1'b1);
      addr_clr = 1'b1;
      send_bit(1'b0);
      send_bit(1'b1);
      addr_clr = 1'b0;
      send_word(16'h0F0F);
      check_count("R5");

      // R10: fill to the top address and push one word past it
      send_word(16'h1111);
      send_word(16'h2222);
      send_word(16'h3333);
      send_word(16'h4444);
      send_word(16'h5555);
      check_flags("R10");
      send_word(16'hBEEF);
      check_count("R10");
      check_flags("R10");
      check(ovf[0] == 1'b1, "R10", "saturate ovf_flag set", ovf[0], 1);

      // R8: partial word at load-complete
      for (int i = 0; i < 3; i++) send_bit(1'b1);
      pulse_done();
      check_flags("R8");
      check(part[0] == 1'b1, "R8", "part_flag set", part[0], 1);

      // R7: edges after load-complete produce nothing
      send_word(16'hDEAD);
      check_count("R7");

      // R9: release hold after load-complete
      set_hold(1'b1);
      check_flags("R9");
      check(run[0] == 1'b1, "R9", "core_run after release", run[0], 1);

      // R4: edges while hold is released
      send_word(16'hCAFE);
      check_count("R4");

      // R12: new session
      set_hold(1'b0);
      check_flags("R12");
      check(ovf[1] == 1'b0, "R12", "ovf_flag cleared", ovf[1], 0);
      send_word(16'h7E81);
      check_count("R12");

      // R9: release without load-complete keeps core_run low
      set_hold(1'b1);
      check_flags("R9");
      check(run[0] == 1'b0, "R9", "core_run without load-complete", run[0], 0);

      // memory image and leftover expectations
      waitc(6);
      for (int p = 0; p < 2; p++) begin
         for (int a = 0; a < MW; a++)
            check(dmem[p][a] == emem[p][a], "R2", $sformatf("memory dut%0d word %0d", p, a),
                  dmem[p][a], emem[p][a]);
         check(((p == 0) ? q0.size() : q1.size()) == 0, "R2",
               $sformatf("missing writes dut%0d", p), (p == 0) ? q0.size() : q1.size(), 0);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule